// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is a byte-wide register file that a host reaches through two ports: an index port that selects one of fourteen registers, and a data port that reads or writes the selected one. Index values 0 to 9 select plain calendar and time-of-day storage bytes. Index 10 is status/control register A, index 11 is status/control register B, and indices 12 and 13 are two status registers that always read as zero. The time bytes do not count on their own. The host or a boot sequence loads them, and they keep whatever was last written.

Register A reports a time-base and rate selection that cannot be changed. Its update-in-progress flag flips on every read, so a polling loop that waits for the flag to change always makes progress. Register B holds the periodic-interrupt enable, the square-wave enable and two format bits that are fixed to binary and 24-hour. While the periodic enable is on, a free-running tick raises a one-cycle interrupt pulse every `TICK_CYCLES` clocks. Any access outside the supported set sets a sticky error output, and that access does not change the state it targeted.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, err is 0, irq is 0, rdata is 0x00, every storage byte holds 0x00, register A holds 0x26 and register B holds 0x46.
- R2: An index write with a value from 0x00 to 0x0D selects that register. A larger value sets err and leaves the selected index unchanged.
- R3: Indices 0 to 9 are plain read/write storage bytes, each independent of the others.
- R4: Every read of register A first inverts bit 7 (update in progress) and then returns the new value. The first read after reset returns 0xA6, the next returns 0x26, and reads keep alternating.
- R5: A write of 0x26 to register A stores it, which also clears bit 7. A write of any other value sets err and leaves A unchanged.
- R6: A write to register B whose bits other than bit 6 (periodic enable) and bit 3 (square-wave enable) equal 0x06 is stored. Any other value sets err and leaves B and the tick unchanged.
- R7: Indices 12 and 13 read as 0x00, and a data write to either of them sets err.
- R8: The tick runs from reset. irq is a one-cycle pulse, first seen TICK_CYCLES clock edges after reset is released and then every TICK_CYCLES edges.
- R9: An accepted B write with bit 6 clear stops the tick, and no pulse follows after the cycle of the write. An accepted write with bit 6 set starts a stopped tick, with the first pulse TICK_CYCLES edges after the write edge. If the tick is already running, such a write leaves its phase unchanged.
- R10: err stays at 1 once set, and only reset clears it.
- R11: rdata takes the selected value on the clock edge that samples data_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Strobe: wdata is a register index |
| data_wr | input | 1 | Strobe: write wdata to the selected register |
| data_rd | input | 1 | Strobe: read the selected register into rdata |
| wdata | input | 8 | Index or data byte |
| rdata | output | 8 | Last value read |
| irq | output | 1 | Periodic interrupt pulse |
| err | output | 1 | Sticky unsupported-access flag |

## Verification
The assertions assume that the host raises at most one of idx_wr, data_wr and data_rd in any cycle, because simultaneous strobes have no defined priority. One check enforces this rule, and every bench task drives exactly one strobe for one cycle. The random stimulus draws most index values inside the legal range and most A and B writes from the legal sets, so that the stored state stays interesting. It still mixes in out-of-range indices and illegal values. The tick checks are directed and measure pulse spacing in counted clock edges.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int TICK_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       err
);
  localparam int         NDATA  = 10;
  localparam int         CW     = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
  localparam logic [3:0] IDX_A  = 4'hA;
  localparam logic [3:0] IDX_B  = 4'hB;
  localparam logic [7:0] IDX_MAX = 8'h0D;
  localparam logic [7:0] A_RST  = 8'h26;
  localparam logic [7:0] B_RST  = 8'h46;
  localparam logic [7:0] B_FREE = 8'h48;
  localparam logic [7:0] B_FIX  = 8'h06;
  localparam logic [7:0] UIP    = 8'h80;

  logic [3:0]    idx;
  logic [7:0]    cal [NDATA];
  logic [7:0]    reg_a, reg_b;
  logic          run;
  logic [CW-1:0] cnt;

  wire b_ok  = (wdata & ~B_FREE) == B_FIX;
  wire b_acc = data_wr && idx == IDX_B && b_ok;
  wire hit   = run && cnt == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      reg_a <= A_RST;
      reg_b <= B_RST;
      rdata <= '0;
      err   <= 1'b0;
      for (int i = 0; i < NDATA; i++) cal[i] <= '0;
    end else begin
      if (idx_wr) begin
        if (wdata <= IDX_MAX) idx <= wdata[3:0];
        else err <= 1'b1;
      end
      if (data_wr) begin
        if (idx < IDX_A) cal[idx] <= wdata;
        else if (idx == IDX_A) begin
          if (wdata == A_RST) reg_a <= wdata;
          else err <= 1'b1;
        end else if (idx == IDX_B) begin
          if (b_ok) reg_b <= wdata;
          else err <= 1'b1;
        end else err <= 1'b1;
      end
      if (data_rd) begin
        if (idx < IDX_A) rdata <= cal[idx];
        else if (idx == IDX_A) begin
          reg_a <= reg_a ^ UIP;
          rdata <= reg_a ^ UIP;
        end else if (idx == IDX_B) rdata <= reg_b;
        else rdata <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b1;
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= hit;
      if (b_acc && !wdata[6]) run <= 1'b0;
      else if (b_acc && !run) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) cnt <= hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

module rtc_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_wr,
  input logic       data_wr,
  input logic       data_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       err,
  input logic [3:0] idx,
  input logic       run
);
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idx_wr, data_wr, data_rd}));

  // R2
  idx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata > 8'h0D) |=> err);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 4'hD);

  // R4
  a_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx == 4'hA) |=> rdata[6:0] == 7'h26);

  // R7
  cd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx >= 4'hC) |=> rdata == 8'h00);

  // R7
  cd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx >= 4'hC) |=> err);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(rdata));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
  .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .irq(irq), .err(err),
  .idx(idx), .run(run)
);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
  localparam int TICK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, err;

  rtc_regfile #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .irq(irq), .err(err)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int cyc = 0, irq_cnt = 0, last_irq = 0, prev_irq = 0, first_irq = 0;

  logic [3:0] m_idx;
  logic [7:0] m_cal [10];
  logic [7:0] m_a, m_b;
  bit m_err;

  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else cyc = cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_cnt = irq_cnt + 1;
      prev_irq = last_irq;
      last_irq = cyc;
      if (first_irq == 0) first_irq = cyc;
    end
  end

  function automatic bit b_legal(logic [7:0] v);
    return (v & 8'hB7) == 8'h06;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idx = 0; m_a = 8'h26; m_b = 8'h46; m_err = 0;
    for (int i = 0; i < 10; i++) m_cal[i] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    model_reset();
    first_irq = 0; irq_cnt = 0; last_irq = 0; prev_irq = 0;
    rst_n = 1;
  endtask

  task automatic do_idx(logic [7:0] v);
    @(negedge clk); idx_wr = 1; wdata = v;
    @(negedge clk); idx_wr = 0;
    if (v <= 8'h0D) m_idx = v[3:0];
    else m_err = 1;
  endtask

  task automatic do_wr(logic [7:0] v);
    @(negedge clk); data_wr = 1; wdata = v;
    @(negedge clk); data_wr = 0;
    if (m_idx < 10) m_cal[m_idx] = v;
    else if (m_idx == 10) begin
      if (v == 8'h26) m_a = v; else m_err = 1;
    end else if (m_idx == 11) begin
      if (b_legal(v)) m_b = v; else m_err = 1;
    end else m_err = 1;
  endtask

  task automatic do_rd(string req);
    logic [7:0] e;
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    if (m_idx < 10) e = m_cal[m_idx];
    else if (m_idx == 10) begin m_a = m_a ^ 8'h80; e = m_a; end
    else if (m_idx == 11) e = m_b;
    else e = 8'h00;
    check(req, rdata, e);
  endtask

  initial begin
    int c, l, w;
    logic [7:0] v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    check("R1 err", err, 0);
    check("R1 irq", irq, 0);
    check("R1 rdata", rdata, 0);
    do_idx(8'h0B); do_rd("R1 reg B");
    do_idx(8'h03); do_rd("R1 storage");

    do_idx(8'h0A);
    do_rd("R4 first"); check("R4 value", rdata, 8'hA6);
    do_rd("R4 second"); check("R4 value", rdata, 8'h26);
    do_rd("R4 third");

    do_idx(8'h05); do_wr(8'h5A);
    do_idx(8'h09); do_wr(8'hC3);
    do_idx(8'h00); do_wr(8'hFF);
    do_idx(8'h05); do_rd("R3 byte5");
    do_idx(8'h09); do_rd("R3 byte9");
    do_idx(8'h00); do_rd("R3 byte0");
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, 8'hFF);

    while (irq_cnt < 2) @(negedge clk);
    check("R8 first pulse", first_irq, TICK);
    check("R8 period", last_irq - prev_irq, TICK);

    c = irq_cnt;
    while (irq_cnt == c) @(negedge clk);
    l = last_irq;
    repeat (3) @(negedge clk);
    do_idx(8'h0B); do_wr(8'h4E);
    c = irq_cnt;
    while (irq_cnt == c) @(negedge clk);
    check("R9 phase kept", last_irq - l, TICK);
    do_rd("R6 stored 4E");

    do_wr(8'h06);
    repeat (2) @(negedge clk);
    c = irq_cnt;
    repeat (3 * TICK) @(negedge clk);
    check("R9 stopped", irq_cnt, c);
    do_wr(8'h46);
    w = cyc;
    c = irq_cnt;
    while (irq_cnt == c) @(negedge clk);
    check("R9 restart", last_irq - w, TICK);
    check("R10 no error yet", err, 0);

    do_idx(8'h04); do_wr(8'h77);
    do_idx(8'hF0);
    check("R2 error", err, 1);
    do_rd("R2 index kept");
    repeat (2) @(negedge clk);
    check("R10 sticky", err, 1);
    do_reset();
    check("R10 reset clears", err, 0);

    do_idx(8'h0A); do_wr(8'h00);
    check("R5 error", err, 1);
    do_rd("R5 unchanged");
    do_wr(8'h26);
    do_rd("R5 legal write");
    do_reset();

    do_idx(8'h0B); do_wr(8'h47);
    check("R6 error", err, 1);
    do_rd("R6 unchanged");
    c = irq_cnt;
    while (irq_cnt == c) @(negedge clk);
    check("R6 tick unaffected", last_irq, TICK);
    do_reset();

    do_idx(8'h0C); do_rd("R7 reg C");
    do_idx(8'h0D); do_rd("R7 reg D");
    check("R7 read no error", err, 0);
    do_wr(8'h01);
    check("R7 write error", err, 1);
    do_reset();

    for (int n = 0; n < 400; n++) begin
      case ($urandom % 3)
        0: begin
          v = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 14);
          do_idx(v);
        end
        1: begin
          if (m_idx == 10) v = ($urandom % 2) ? 8'h26 : 8'($urandom);
          else if (m_idx == 11) begin
            case ($urandom % 5)
              0: v = 8'h06; 1: v = 8'h0E; 2: v = 8'h46; 3: v = 8'h4E;
              default: v = 8'($urandom);
            endcase
          end else v = 8'($urandom);
          do_wr(v);
        end
        default: do_rd("R3/R4/R11 random read");
      endcase
      check("R10 random err", err, m_err);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule